// File: doc/BRIEF.md
# Servo Pulse Decoder and Drive Mixer

This block takes two servo-style pulse lines from a radio receiver and measures how long each pulse stays high, counting strobes of a one-microsecond timebase. It checks each width against an allowed window, tracks how recently each line produced a rising edge, and turns each accepted width into a signed speed command centred on zero. A mixing stage then maps the two channel commands onto two motor commands. Three static strap inputs choose the mapping: direct, elevon-style mixing, or a single combined channel. A swap-and-reverse option also applies to the direct and mixing mappings.

If either channel has no acceptable pulse, or has gone quiet, both motor commands are held at zero and a failsafe flag is raised. The block is placed between a receiver input stage and a motor PWM stage. The motor side consumes the two registered commands directly.

Top module: `rc_cmd_mixer`

## Requirements
- R1: A pulse width is the number of `tick_i` strobes seen while the synchronised pulse line is high. A pulse is accepted only if its width lies in MIN_US..MAX_US inclusive (default 1100..1900). A width of 1099 or 1901 makes the channel invalid when its falling edge is seen.
- R2: A channel becomes invalid when TIMEOUT_US strobes (default 50000) pass after its last rising edge with no new rising edge.
- R3: While either channel is invalid, including from reset until both have delivered an accepted pulse, `failsafe_o` is 1 and both commands are 0.
- R4: A channel command is the truncated value of (width − CENTER_US) × 511 / SPAN_US. With the defaults, 1500 gives 0, 1100 gives −511 and 1900 gives +511.
- R5: In direct mode (no straps set), motor A follows channel 1 and motor B follows channel 2.
- R6: With `mix_i` = 1, channel 1 is the turn term and channel 2 is the common term: A = c2 + c1 and B = c2 − c1. Each result saturates to ±511.
- R7: With `combine_i` = 1 and `mix_i` = 0, both motors get the channel 1 command and `invert_i` has no effect.
- R8: With both `mix_i` and `combine_i` set, the outputs equal those of mix mode.
- R9: In direct and mix modes, `invert_i` = 1 gives A' = −B and B' = −A, where A and B are the outputs the mode would give without inversion.
- R10: The last accepted width is held until the next falling edge. A new accepted pulse after a failsafe restores the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-microsecond timebase strobe |
| ch1_pulse_i | input | 1 | Channel 1 servo pulse (asynchronous) |
| ch2_pulse_i | input | 1 | Channel 2 servo pulse (asynchronous) |
| mix_i | input | 1 | Elevon mix strap |
| combine_i | input | 1 | Single combined channel strap |
| invert_i | input | 1 | Swap and reverse strap |
| cmd_a_o | output | 10 | Signed motor A command, ±511 |
| cmd_b_o | output | 10 | Signed motor B command, ±511 |
| failsafe_o | output | 1 | Both commands forced to zero |

## Verification
The bench keeps the default pulse window, centre and span. It strobes `tick_i` on every clock, so one cycle of high time counts as one microsecond. This lets it place widths exactly one step inside and one step outside the window. The bench shortens TIMEOUT_US to 3000, so the loss-of-signal path can be reached in a few thousand cycles. Frames still repeat quickly enough that normal traffic never trips it. With that value, the bench can check both sides of the timeout and the recovery that follows.

// File: rtl/rc_mix_pkg.sv
`timescale 1ns/1ps
package rc_mix_pkg;
  localparam int CMD_W   = 10;
  localparam int CMD_MAX = 2 ** (CMD_W - 1) - 1;

  typedef logic signed [CMD_W-1:0] cmd_t;
  typedef enum logic [1:0] {MODE_DIRECT, MODE_MIX, MODE_COMBINE} mode_e;

  function automatic cmd_t sat_cmd(input logic signed [CMD_W:0] v);
    if (v > CMD_MAX)       return cmd_t'(CMD_MAX);
    else if (v < -CMD_MAX) return cmd_t'(-CMD_MAX);
    else                   return cmd_t'(v);
  endfunction
endpackage

// File: rtl/rc_pulse_meas.sv
`timescale 1ns/1ps
module rc_pulse_meas #(
  parameter int MIN_US     = 1100,
  parameter int MAX_US     = 1900,
  parameter int TIMEOUT_US = 50000,
  parameter int W_W        = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           pulse_i,
  output logic [W_W-1:0] width_o,
  output logic           valid_o
);
  localparam int G_W = $clog2(TIMEOUT_US + 1);
  localparam logic [W_W-1:0] W_SAT = '1;

  logic [2:0]     sync_q;
  logic [W_W-1:0] cnt_q;
  logic [G_W-1:0] gap_q;
  logic           lvl, rise, fall, timed_out, in_range;

  assign lvl       = sync_q[1];
  assign rise      = sync_q[1] & ~sync_q[2];
  assign fall      = ~sync_q[1] & sync_q[2];
  assign timed_out = (gap_q == G_W'(TIMEOUT_US));
  assign in_range  = (cnt_q >= W_W'(MIN_US)) && (cnt_q <= W_W'(MAX_US));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pulse_i};
  end

  // width in ticks while high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (rise)                            cnt_q <= tick_i ? W_W'(1) : '0;
    else if (lvl && tick_i && cnt_q != W_SAT) cnt_q <= cnt_q + 1'b1;
  end

  // ticks since last rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (rise)                   gap_q <= '0;
    else if (tick_i && !timed_out)   gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o <= '0;
      valid_o <= 1'b0;
    end else if (fall) begin
      width_o <= cnt_q;
      valid_o <= in_range;
    end else if (timed_out) begin
      valid_o <= 1'b0;
    end
  end

  // R1
  valid_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (width_o >= W_W'(MIN_US) && width_o <= W_W'(MAX_US)));
  // R2
  timeout_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_out && !fall) |=> !valid_o);
endmodule

// File: rtl/rc_width_to_cmd.sv
`timescale 1ns/1ps
module rc_width_to_cmd
  import rc_mix_pkg::*;
#(
  parameter int CENTER_US = 1500,
  parameter int SPAN_US   = 400,
  parameter int W_W       = 11
) (
  input  logic [W_W-1:0] width_i,
  output cmd_t           cmd_o
);
  localparam int PW = W_W + CMD_W + 2;

  logic signed [PW-1:0] diff, prod, quo;

  always_comb begin
    diff = $signed(PW'(width_i)) - $signed(PW'(CENTER_US));
    prod = diff * $signed(PW'(CMD_MAX));
    quo  = prod / $signed(PW'(SPAN_US));
    if (quo > CMD_MAX)       cmd_o = cmd_t'(CMD_MAX);
    else if (quo < -CMD_MAX) cmd_o = cmd_t'(-CMD_MAX);
    else                     cmd_o = cmd_t'(quo);
  end
endmodule

// File: rtl/rc_cmd_mix.sv
`timescale 1ns/1ps
module rc_cmd_mix
  import rc_mix_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t c1_i,
  input  cmd_t c2_i,
  input  logic ok_i,
  input  logic mix_i,
  input  logic combine_i,
  input  logic invert_i,
  output cmd_t a_o,
  output cmd_t b_o,
  output logic fs_o
);
  mode_e mode;
  cmd_t  sum_c, dif_c, pa, pb, na, nb;

  always_comb begin
    if (mix_i)          mode = MODE_MIX;
    else if (combine_i) mode = MODE_COMBINE;
    else                mode = MODE_DIRECT;

    sum_c = sat_cmd((CMD_W+1)'(c2_i) + (CMD_W+1)'(c1_i));
    dif_c = sat_cmd((CMD_W+1)'(c2_i) - (CMD_W+1)'(c1_i));

    unique case (mode)
      MODE_MIX:     begin pa = sum_c; pb = dif_c; end
      MODE_COMBINE: begin pa = c1_i;  pb = c1_i;  end
      default:      begin pa = c1_i;  pb = c2_i;  end
    endcase

    if (invert_i && mode != MODE_COMBINE) begin
      na = -pb;
      nb = -pa;
    end else begin
      na = pa;
      nb = pb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o  <= '0;
      b_o  <= '0;
      fs_o <= 1'b1;
    end else begin
      a_o  <= ok_i ? na : '0;
      b_o  <= ok_i ? nb : '0;
      fs_o <= !ok_i;
    end
  end

  // R3
  failsafe_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> (a_o == '0 && b_o == '0));
  // R6
  cmd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_o >= -CMD_MAX && a_o <= CMD_MAX && b_o >= -CMD_MAX && b_o <= CMD_MAX));
  // R7
  combine_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(combine_i) && !$past(mix_i)) |-> (a_o == b_o));
endmodule

// File: rtl/rc_cmd_mixer.sv
`timescale 1ns/1ps
module rc_cmd_mixer
  import rc_mix_pkg::*;
#(
  parameter int MIN_US     = 1100,
  parameter int MAX_US     = 1900,
  parameter int CENTER_US  = 1500,
  parameter int SPAN_US    = 400,
  parameter int TIMEOUT_US = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ch1_pulse_i,
  input  logic              ch2_pulse_i,
  input  logic              mix_i,
  input  logic              combine_i,
  input  logic              invert_i,
  output logic [CMD_W-1:0]  cmd_a_o,
  output logic [CMD_W-1:0]  cmd_b_o,
  output logic              failsafe_o
);
  localparam int NCH = 2;
  localparam int W_W = $clog2(MAX_US + 2);

  logic [NCH-1:0] pulse_w, ok_w;
  logic [W_W-1:0] width_w [NCH];
  cmd_t           cmd_w   [NCH];
  cmd_t           a_w, b_w;

  assign pulse_w = {ch2_pulse_i, ch1_pulse_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rc_pulse_meas #(
      .MIN_US(MIN_US), .MAX_US(MAX_US), .TIMEOUT_US(TIMEOUT_US), .W_W(W_W)
    ) u_meas (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pulse_i(pulse_w[g]),
      .width_o(width_w[g]), .valid_o(ok_w[g])
    );
    rc_width_to_cmd #(
      .CENTER_US(CENTER_US), .SPAN_US(SPAN_US), .W_W(W_W)
    ) u_conv (
      .width_i(width_w[g]), .cmd_o(cmd_w[g])
    );
  end

  rc_cmd_mix u_mix (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .c1_i(cmd_w[0]), .c2_i(cmd_w[1]), .ok_i(&ok_w),
    .mix_i(mix_i), .combine_i(combine_i), .invert_i(invert_i),
    .a_o(a_w), .b_o(b_w), .fs_o(failsafe_o)
  );

  assign cmd_a_o = a_w;
  assign cmd_b_o = b_w;
endmodule

// File: tb/rc_cmd_mixer_tb.sv
`timescale 1ns/1ps
module rc_cmd_mixer_tb;
  localparam int FRAME = 2200;
  localparam int TMO   = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ch1 = 1'b0, ch2 = 1'b0, mix = 1'b0, comb = 1'b0, inv = 1'b0;
  logic [9:0] cmd_a, cmd_b;
  logic fs;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rc_cmd_mixer #(.TIMEOUT_US(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1),
    .ch1_pulse_i(ch1), .ch2_pulse_i(ch2),
    .mix_i(mix), .combine_i(comb), .invert_i(inv),
    .cmd_a_o(cmd_a), .cmd_b_o(cmd_b), .failsafe_o(fs)
  );

  function automatic int conv(int w);
    return ((w - 1500) * 511) / 400;
  endfunction

  function automatic int sat(int v);
    return (v > 511) ? 511 : (v < -511) ? -511 : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, int ea, int eb, int efs);
    chk({req, " A"}, int'($signed(cmd_a)), ea);
    chk({req, " B"}, int'($signed(cmd_b)), eb);
    chk({req, " failsafe"}, int'(fs), efs);
  endtask

  task automatic frame(int w1, int w2);
    @(negedge clk);
    ch1 = 1'b1; ch2 = 1'b1;
    for (int k = 0; k < FRAME; k++) begin
      if (k == w1) ch1 = 1'b0;
      if (k == w2) ch2 = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic straps(logic m, logic c, logic i);
    @(negedge clk);
    mix = m; comb = c; inv = i;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    // R3: reset state
    repeat (3) @(negedge clk);
    chk_out("R3 reset", 0, 0, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_out("R3 no pulses yet", 0, 0, 1);
  endtask

  task automatic t_direct();
    straps(0, 0, 0);
    frame(1500, 1500); chk_out("R4 R5 centre", 0, 0, 0);
    frame(1700, 1300); chk_out("R4 R5 direct", conv(1700), conv(1300), 0);
    frame(1100, 1900); chk_out("R1 R4 window edges", -511, 511, 0);
    frame(1900, 1100); chk_out("R1 R4 window edges swap", 511, -511, 0);
  endtask

  task automatic t_bounds();
    frame(1099, 1500); chk_out("R1 short ch1", 0, 0, 1);
    frame(1500, 1901); chk_out("R1 long ch2", 0, 0, 1);
    frame(1650, 1420); chk_out("R10 recovery", conv(1650), conv(1420), 0);
  endtask

  task automatic t_mix();
    int c1, c2;
    c1 = conv(1700); c2 = conv(1600);
    straps(1, 0, 0);
    frame(1700, 1600); chk_out("R6 mix", sat(c2 + c1), sat(c2 - c1), 0);
    straps(1, 0, 1);
    chk_out("R9 mix invert", -sat(c2 - c1), -sat(c2 + c1), 0);
    straps(1, 0, 0);
    frame(1900, 1900); chk_out("R6 mix saturate", 511, 0, 0);
    frame(1900, 1100); chk_out("R6 mix saturate low", 0, -511, 0);
    straps(1, 1, 0);
    chk_out("R8 both straps", 0, -511, 0);
  endtask

  task automatic t_invert_combine();
    straps(0, 0, 1);
    frame(1800, 1250);
    chk_out("R9 direct invert", -conv(1250), -conv(1800), 0);
    straps(0, 1, 0);
    chk_out("R7 combine", conv(1800), conv(1800), 0);
    straps(0, 1, 1);
    chk_out("R7 combine invert ignored", conv(1800), conv(1800), 0);
    straps(0, 0, 0);
  endtask

  task automatic t_timeout();
    frame(1600, 1400);
    // ~2200 cycles since rise
    repeat (500) @(negedge clk);
    chk_out("R10 hold before timeout", conv(1600), conv(1400), 0);
    repeat (500) @(negedge clk);
    chk_out("R2 timeout", 0, 0, 1);
    frame(1600, 1400);
    chk_out("R2 R10 recover after timeout", conv(1600), conv(1400), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_direct();
    t_bounds();
    t_mix();
    t_invert_combine();
    t_timeout();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule